// File: doc/BRIEF.md
# Sliding Window Fingerprint Matcher

This block finds where a short query of cycle-length samples lines up best inside a longer, timestamped reference trace. Software or an upstream stage first fills a query store of `N_LEN` samples and a reference store of `N_LEN + MARGIN` samples, each reference slot carrying a 32-bit timestamp next to its 16-bit sample. A start strobe then launches one search.

Every candidate window start `w` in `0 .. MARGIN` gets a sum of squared differences between the query and the `N_LEN` reference slots beginning at `w`. All windows are scored in parallel, one query sample per cycle. A serial scan then picks the smallest sum. The block reports three things: the winning start slot, its sum, and the timestamp of the last reference slot that the winning window covers (slot `w + N_LEN - 1`). That timestamp is the local time that matches the query's final sample.

Top module: `fpm_matcher`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `best_idx`, `best_ts` and `best_sse` are all zero.
- R2: When `q_wr_en` is high, `q_wr_data` goes into query slot `q_wr_addr`. When `r_wr_en` is high, `r_wr_data` and `r_wr_ts` go into reference slot `r_wr_addr`. Writes made while `busy` is high are ignored.
- R3: The score of a window is the sum over k of (query[k] - ref[w+k])², with each difference taken as a signed 17-bit value. The accumulator never wraps, even when every difference is ±65535.
- R4: `best_sse` reports the smallest window score, and `best_idx` reports the zero-based start slot of the window that produced it.
- R5: When several windows share the smallest score, the one with the lowest start slot is reported.
- R6: `best_ts` equals the timestamp stored in reference slot `best_idx + N_LEN - 1`.
- R7: `done` is a single-cycle pulse that arrives exactly `N_LEN + MARGIN + 2` clock edges after the edge that samples `start`. `busy` is high from the edge that samples `start` until the edge that raises `done`, and `done` is never high together with `busy`.
- R8: `best_idx`, `best_ts` and `best_sse` change only on the edge that raises `done`. A `start` strobe that arrives while `busy` is high is ignored.
- R9: Every start slot from 0 through `MARGIN` is a candidate, so a match at slot `MARGIN` (where the window ends on the last reference slot) is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_wr_en | input | 1 | Query slot write enable |
| q_wr_addr | input | 3 | Query slot address |
| q_wr_data | input | 16 | Query sample |
| r_wr_en | input | 1 | Reference slot write enable |
| r_wr_addr | input | 4 | Reference slot address |
| r_wr_data | input | 16 | Reference sample |
| r_wr_ts | input | 32 | Timestamp stored with the reference sample |
| start | input | 1 | Start strobe, accepted only while idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_idx | output | 4 | Zero-based start slot of the winning window |
| best_ts | output | 32 | Timestamp of the winning window's last slot |
| best_sse | output | 36 | Winning sum of squared differences |

## Verification
The hardest cases to reach from the ports are exact ties between windows and the extreme where every difference has the full 16-bit magnitude. The stimulus creates ties on purpose with a constant trace and with a trace whose period divides the window spacing, and it creates the extreme case with an all-zero query against an all-ones reference. A further run writes new data into both stores and pulses `start` again while the search is running. The check is that the reported result still matches the data loaded before the start, and that `done` arrives only once, at the expected cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int SAMPLE_W = 16;
    localparam int TS_W     = 32;
    localparam int SQ_W     = 2 * SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [TS_W-1:0]     stamp_t;
    typedef logic [SQ_W-1:0]     sq_t;

    typedef struct packed {
        sample_t val;
        stamp_t  ts;
    } ref_slot_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_SCAN,
        ST_COMMIT
    } run_state_t;

    function automatic int idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    // Square of the signed difference between two unsigned samples.
    function automatic sq_t sq_diff(input sample_t a, input sample_t b);
        logic signed [SAMPLE_W:0] d;
        logic        [SAMPLE_W:0] mag;
        sq_t                      m;
        d   = $signed({1'b0, a}) - $signed({1'b0, b});
        mag = d[SAMPLE_W] ? unsigned'(-d) : unsigned'(d);
        m   = sq_t'(mag);
        return m * m;
    endfunction

endpackage

// File: rtl/fpm_sample_store.sv
module fpm_sample_store
    import fpm_pkg::*;
#(
    parameter int N_LEN   = 8,
    parameter int REF_LEN = 16,
    localparam int QA_W   = idx_w(N_LEN),
    localparam int RA_W   = idx_w(REF_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic             q_wr_en,
    input  logic [QA_W-1:0]  q_wr_addr,
    input  sample_t          q_wr_data,
    input  logic             r_wr_en,
    input  logic [RA_W-1:0]  r_wr_addr,
    input  sample_t          r_wr_data,
    input  stamp_t           r_wr_ts,
    output sample_t          q_out [N_LEN],
    output ref_slot_t        r_out [REF_LEN]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LEN; i++) q_out[i] <= '0;
        end else if (q_wr_en && !lock && int'(q_wr_addr) < N_LEN) begin
            q_out[q_wr_addr] <= q_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REF_LEN; i++) r_out[i] <= '0;
        end else if (r_wr_en && !lock && int'(r_wr_addr) < REF_LEN) begin
            r_out[r_wr_addr] <= '{val: r_wr_data, ts: r_wr_ts};
        end
    end

    // R2: locked stores hold the slots that a write would target
    assert_lock_query_R2: assert property (@(posedge clk) disable iff (rst)
        (lock && q_wr_en) |=> $stable(q_out[0]) && $stable(q_out[N_LEN-1]));
    assert_lock_ref_R2: assert property (@(posedge clk) disable iff (rst)
        (lock && r_wr_en) |=> $stable(r_out[0]) && $stable(r_out[REF_LEN-1]));

endmodule

// File: rtl/fpm_sse_lane.sv
module fpm_sse_lane
    import fpm_pkg::*;
#(
    parameter int ACC_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  sample_t          a,
    input  sample_t          b,
    output logic [ACC_W-1:0] sum
);

    sq_t sq;
    assign sq = sq_diff(a, b);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum <= '0;
        end else if (en) begin
            sum <= sum + ACC_W'(sq);
        end
    end

    // R3: accumulation only grows, so it never wraps
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !clear) |=> sum >= $past(sum));

endmodule

// File: rtl/fpm_best_select.sv
module fpm_best_select #(
    parameter int ACC_W = 36,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic             scan_first,
    input  logic [ACC_W-1:0] cand_sum,
    input  logic [IW-1:0]    cand_idx,
    output logic [ACC_W-1:0] min_sum,
    output logic [IW-1:0]    min_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            min_sum <= '0;
            min_idx <= '0;
        end else if (scan_en && (scan_first || cand_sum < min_sum)) begin
            min_sum <= cand_sum;
            min_idx <= cand_idx;
        end
    end

    // R4: the running minimum never rises during a scan
    assert_min_monotone_R4: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !scan_first) |=> min_sum <= $past(min_sum));
    // R5: an equal later candidate leaves the earlier winner in place
    assert_tie_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !scan_first && cand_sum == min_sum) |=> min_idx == $past(min_idx));

endmodule

// File: rtl/fpm_matcher.sv
module fpm_matcher
    import fpm_pkg::*;
#(
    parameter int N_LEN   = 8,
    parameter int MARGIN  = 8,
    localparam int REF_LEN = N_LEN + MARGIN,
    localparam int NUM_WIN = MARGIN + 1,
    localparam int QA_W    = idx_w(N_LEN),
    localparam int RA_W    = idx_w(REF_LEN),
    localparam int IW      = idx_w(NUM_WIN),
    localparam int ACC_W   = SQ_W + $clog2(N_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_wr_en,
    input  logic [QA_W-1:0]  q_wr_addr,
    input  logic [15:0]      q_wr_data,
    input  logic             r_wr_en,
    input  logic [RA_W-1:0]  r_wr_addr,
    input  logic [15:0]      r_wr_data,
    input  logic [31:0]      r_wr_ts,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [IW-1:0]    best_idx,
    output logic [31:0]      best_ts,
    output logic [ACC_W-1:0] best_sse
);

    run_state_t       state;
    logic [QA_W-1:0]  k_cnt;
    logic [IW-1:0]    s_cnt;
    logic             go;

    sample_t          q_mem [N_LEN];
    ref_slot_t        r_mem [REF_LEN];
    logic [ACC_W-1:0] lane_sum [NUM_WIN];
    logic [ACC_W-1:0] min_sum;
    logic [IW-1:0]    min_idx;

    assign busy = (state != ST_IDLE);
    assign go   = start && (state == ST_IDLE);

    fpm_sample_store #(.N_LEN(N_LEN), .REF_LEN(REF_LEN)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lock      (busy),
        .q_wr_en   (q_wr_en),
        .q_wr_addr (q_wr_addr),
        .q_wr_data (q_wr_data),
        .r_wr_en   (r_wr_en),
        .r_wr_addr (r_wr_addr),
        .r_wr_data (r_wr_data),
        .r_wr_ts   (r_wr_ts),
        .q_out     (q_mem),
        .r_out     (r_mem)
    );

    // One lane per candidate start slot; all lanes step through the query together.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_lane
        fpm_sse_lane #(.ACC_W(ACC_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .clear (go),
            .en    (state == ST_ACCUM),
            .a     (q_mem[k_cnt]),
            .b     (r_mem[RA_W'(w) + RA_W'(k_cnt)].val),
            .sum   (lane_sum[w])
        );
    end

    fpm_best_select #(.ACC_W(ACC_W), .IW(IW)) u_select (
        .clk        (clk),
        .rst        (rst),
        .scan_en    (state == ST_SCAN),
        .scan_first (s_cnt == '0),
        .cand_sum   (lane_sum[s_cnt]),
        .cand_idx   (s_cnt),
        .min_sum    (min_sum),
        .min_idx    (min_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            k_cnt    <= '0;
            s_cnt    <= '0;
            done     <= 1'b0;
            best_idx <= '0;
            best_ts  <= '0;
            best_sse <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        state <= ST_ACCUM;
                        k_cnt <= '0;
                    end
                end
                ST_ACCUM: begin
                    if (k_cnt == QA_W'(N_LEN - 1)) begin
                        state <= ST_SCAN;
                        s_cnt <= '0;
                    end else begin
                        k_cnt <= k_cnt + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (s_cnt == IW'(NUM_WIN - 1)) begin
                        state <= ST_COMMIT;
                    end else begin
                        s_cnt <= s_cnt + 1'b1;
                    end
                end
                ST_COMMIT: begin
                    state    <= ST_IDLE;
                    done     <= 1'b1;
                    best_idx <= min_idx;
                    best_sse <= min_sum;
                    best_ts  <= r_mem[RA_W'(min_idx) + RA_W'(N_LEN - 1)].ts;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(best_idx) && $stable(best_ts) && $stable(best_sse));
    assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> int'(best_idx) <= MARGIN);

endmodule

// File: tb/tb_fpm_matcher.sv
module tb_fpm_matcher;

    localparam int N   = 8;
    localparam int L   = 8;
    localparam int M   = N + L;
    localparam int NW  = L + 1;
    localparam int LAT = N + NW + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        q_wr_en = 1'b0;
    logic [2:0]  q_wr_addr = '0;
    logic [15:0] q_wr_data = '0;
    logic        r_wr_en = 1'b0;
    logic [3:0]  r_wr_addr = '0;
    logic [15:0] r_wr_data = '0;
    logic [31:0] r_wr_ts = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [3:0]  best_idx;
    logic [31:0] best_ts;
    logic [35:0] best_sse;

    always #2 clk = ~clk;

    fpm_matcher #(.N_LEN(N), .MARGIN(L)) dut (
        .clk(clk), .rst(rst),
        .q_wr_en(q_wr_en), .q_wr_addr(q_wr_addr), .q_wr_data(q_wr_data),
        .r_wr_en(r_wr_en), .r_wr_addr(r_wr_addr), .r_wr_data(r_wr_data), .r_wr_ts(r_wr_ts),
        .start(start), .busy(busy), .done(done),
        .best_idx(best_idx), .best_ts(best_ts), .best_sse(best_sse)
    );

    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    int          qm [N];
    int          rm [M];
    bit [31:0]   tm [M];
    bit [31:0]   seed = 32'h1234_5678;
    longint      e_sse;
    int          e_idx;
    longint      e_ts;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nxt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[31:16]);
    endfunction

    // Behavioural reference: score each window, keep the first strict minimum.
    task automatic expect_result();
        e_sse = -1;
        e_idx = 0;
        for (int w = 0; w < NW; w++) begin
            longint s = 0;
            for (int k = 0; k < N; k++) begin
                longint d = longint'(qm[k]) - longint'(rm[w + k]);
                s += d * d;
            end
            if (e_sse < 0 || s < e_sse) begin
                e_sse = s;
                e_idx = w;
            end
        end
        e_ts = longint'(tm[e_idx + N - 1]);
    endtask

    task automatic put_q(input int i, input int v);
        @(negedge clk);
        q_wr_en = 1'b1; q_wr_addr = 3'(i); q_wr_data = 16'(v);
        @(negedge clk);
        q_wr_en = 1'b0;
        qm[i] = v;
    endtask

    task automatic put_r(input int i, input int v, input bit [31:0] t);
        @(negedge clk);
        r_wr_en = 1'b1; r_wr_addr = 4'(i); r_wr_data = 16'(v); r_wr_ts = t;
        @(negedge clk);
        r_wr_en = 1'b0;
        rm[i] = v;
        tm[i] = t;
    endtask

    // Runs one search and compares the ports on every cycle against the model.
    task automatic run(input string tag, input bit poke);
        logic [3:0]  p_idx;
        logic [31:0] p_ts;
        logic [35:0] p_sse;
        p_idx = best_idx; p_ts = best_ts; p_sse = best_sse;
        expect_result();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= LAT + 1; j++) begin
            chk({"R7 busy ", tag}, busy, (j < LAT) ? 1 : 0);
            chk({"R7 done ", tag}, done, (j == LAT) ? 1 : 0);
            if (j < LAT) begin
                chk({"R8 hold idx ", tag}, best_idx, p_idx);
                chk({"R8 hold ts ", tag}, best_ts, p_ts);
                chk({"R8 hold sse ", tag}, best_sse, p_sse);
            end else begin
                chk({"R4 idx ", tag}, best_idx, e_idx);
                chk({"R4 sse ", tag}, best_sse, e_sse);
                chk({"R6 ts ", tag}, best_ts, e_ts);
            end
            if (poke && j == 2) begin
                // R2 and R8: writes and a second start during a search are ignored
                start = 1'b1;
                q_wr_en = 1'b1; q_wr_addr = 3'd0; q_wr_data = 16'hBEEF;
                r_wr_en = 1'b1; r_wr_addr = 4'd5; r_wr_data = 16'h0001; r_wr_ts = 32'hDEAD_0000;
            end else begin
                start = 1'b0; q_wr_en = 1'b0; r_wr_en = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic load_ref(input int kind, input bit [31:0] base);
        for (int i = 0; i < M; i++) begin
            int v;
            case (kind)
                0: v = 20000 + (nxt() % 200);
                1: v = 500;
                2: v = (i % 4) * 100;
                default: v = 65535;
            endcase
            put_r(i, v, base + 32'(i) * 32'd20015);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 idx", best_idx, 0);
        chk("R1 ts", best_ts, 0);
        chk("R1 sse", best_sse, 0);

        // R3 R4 R6: noisy trace, query taken from slot 3 with small perturbations
        load_ref(0, 32'h1000_0000);
        for (int k = 0; k < N; k++) put_q(k, rm[3 + k] + ((k % 3) - 1) * 2);
        run("planted3", 1'b0);

        // R9: match in the last candidate slot
        for (int k = 0; k < N; k++) put_q(k, rm[L + k]);
        run("last_slot_R9", 1'b0);

        // R9: match at slot zero
        for (int k = 0; k < N; k++) put_q(k, rm[k] + 1);
        run("first_slot", 1'b0);

        // R5: constant trace, every window ties at zero
        load_ref(1, 32'h2000_0000);
        for (int k = 0; k < N; k++) put_q(k, 500);
        run("flat_tie_R5", 1'b0);

        // R5: period-4 trace, slots 1 and 5 both match exactly
        load_ref(2, 32'h3000_0000);
        for (int k = 0; k < N; k++) put_q(k, rm[1 + k]);
        run("periodic_tie_R5", 1'b0);

        // R3: full-scale differences in both signs
        load_ref(3, 32'h4000_0000);
        for (int k = 0; k < N; k++) put_q(k, 0);
        run("max_pos_R3", 1'b0);
        for (int i = 0; i < M; i++) put_r(i, 0, tm[i]);
        for (int k = 0; k < N; k++) put_q(k, 65535);
        run("max_neg_R3", 1'b0);

        // R2 R8: writes and start during busy are ignored
        load_ref(0, 32'h5000_0000);
        for (int k = 0; k < N; k++) put_q(k, rm[6 + k]);
        run("poke_R2", 1'b1);
        run("rerun_after_poke_R2", 1'b0);

        // R8: result persists while idle
        repeat (5) @(negedge clk);
        chk("R8 idle idx", best_idx, e_idx);
        chk("R8 idle ts", best_ts, e_ts);
        chk("R8 idle sse", best_sse, e_sse);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule